// File: doc/BRIEF.md
# Strobe-Driven FIFO with Read Replay

This block is a single-clock first-in first-out buffer, 512 words of 9 bits by default. It is controlled by active-low write and read strobes instead of enables. The block samples each strobe on the system clock and detects its edges. A write is committed when its strobe returns high. A read starts when its strobe goes low, and the word then appears on a registered output together with an output-enable meant to drive an external three-state bus. Separate write and read pointers track the stored words. Active-low empty, half-full and full flags come from an occupancy count.

An active-low replay input rewinds the read pointer to location zero so that the stored words can be read out again. Replay works at any fill level, including full, and writes keep landing while it is held. An active-low master reset clears the block asynchronously. A short recovery window follows the reset, and strobe activity that begins in that window is discarded.

Top module: `strobe_fifo`

## Requirements
- R1: Words are read out in the order in which they were written, with 9-bit data and 512 locations by default.
- R2: A write is committed on the first clock at which `wr_n` is sampled high after having been sampled low. The word stored is the `din` value sampled on that clock.
- R3: A read is accepted on the first clock at which `rd_n` is sampled low after having been sampled high. On the next clock `dout` holds the word and `dout_oe` is 1. `dout_oe` returns to 0 one clock after `rd_n` is sampled high again.
- R4: A read start while the buffer is empty is ignored: `dout_oe` stays 0 and the read pointer does not move. A write commit while the buffer is full is ignored: the write pointer does not move and no stored word changes.
- R5: `empty_n` is 0 exactly when the occupancy is 0. `half_n` is 0 exactly when the occupancy is at least 256. `full_n` is 0 exactly when the occupancy is 512. The occupancy never exceeds 512.
- R6: A write commit and a read start sampled on the same clock both take effect, and the occupancy is unchanged. Each inhibit in R4 is judged on the occupancy before that clock, so at empty only the write lands and at full only the read lands.
- R7: On every clock at which `rtx_n` is sampled low, the read pointer is set to 0 and read starts are ignored. On release the occupancy equals the write pointer, or 512 if the write pointer is 0 and at least one word has been written since reset.
- R8: Write commits during replay proceed normally and are counted in the occupancy after release.
- R9: `mrst_n` low clears both pointers, the occupancy and `dout_oe` at once. The first 4 clocks after release are a recovery window. A write whose falling edge of `wr_n` was not seen after that window is never committed, and read starts inside the window are ignored.
- R10: A replay while the buffer is full keeps `full_n` at 0. All 512 words can then be read again in their original order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| mrst_n | input | 1 | Active-low asynchronous master reset |
| wr_n | input | 1 | Active-low write strobe; commits on its rising edge |
| rd_n | input | 1 | Active-low read strobe; starts a read on its falling edge |
| rtx_n | input | 1 | Active-low replay; rewinds the read pointer while low |
| din | input | DATA_W | Write data, sampled when the write commits |
| dout | output | DATA_W | Registered read data |
| dout_oe | output | 1 | Enable for an external three-state driver of `dout` |
| empty_n | output | 1 | Active-low empty flag |
| half_n | output | 1 | Active-low half-full flag |
| full_n | output | 1 | Active-low full flag |

## Verification
The bench steers at the boundaries where a flawed buffer would go wrong. These include a read at empty, a write at full, and a write and read landing together at both empty and full. A design that let a read through at empty would raise the enable with stale data. A design that accepted a write at full would overwrite location zero, which the replay readback of all 512 words exposes. The half-full threshold is tested at exactly 255 and 256 words. Replay is tested while full and with a write landing during the rewind, where a wrong occupancy rebuild would leave the buffer showing empty or return too few words. The reset test holds a write strobe low across the recovery window, where an edge detector without arming would commit a phantom word.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

   // Edge events extracted from one sampled active-low strobe
   typedef struct packed {
      logic level;
      logic fell;
      logic rose;
   } strobe_ev_t;

   // Number of strobe inputs handled by the edge stage: write, read, replay
   localparam int STROBE_CNT = 3;
   localparam int IDX_WR     = 0;
   localparam int IDX_RD     = 1;
   localparam int IDX_RTX    = 2;

   // Occupancy seen right after a rewind of the read pointer to zero
   function automatic int unsigned rewind_fill(input int unsigned wptr,
                                               input bit wrote_any,
                                               input int unsigned depth);
      if (wptr != 0)
         return wptr;
      return wrote_any ? depth : 0;
   endfunction

endpackage

// File: rtl/sfifo_strobe_edge.sv
module sfifo_strobe_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   strobe_n,
   output sfifo_pkg::strobe_ev_t  ev
);
   logic samp;
   logic prev;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign samp = strobe_n;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= '1;
            end else begin
               chain[0] <= strobe_n;
               for (int i = 1; i < SYNC_STAGES; i++)
                  chain[i] <= chain[i-1];
            end
         end
         assign samp = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= samp;
   end

   assign ev.level = samp;
   assign ev.fell  = prev & ~samp;
   assign ev.rose  = ~prev & samp;

endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
   parameter int DATA_W = 9,
   parameter int DEPTH  = 512,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (rd_en) rd_data <= mem[rd_addr];
   end

endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl #(
   parameter int DEPTH     = 512,
   parameter int RECOV_CYC = 4,
   localparam int AW       = $clog2(DEPTH),
   localparam int CW       = AW + 1,
   localparam int RW       = $clog2(RECOV_CYC + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_fell,
   input  logic          wr_rose,
   input  logic          rd_fell,
   input  logic          rd_rose,
   input  logic          rtx_level,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic          rd_en,
   output logic [AW-1:0] rd_addr,
   output logic          rewind,
   output logic [CW-1:0] fill,
   output logic          oe,
   output logic          empty_n,
   output logic          half_n,
   output logic          full_n
);
   localparam logic [CW-1:0] FULL_C  = CW'(DEPTH);
   localparam logic [CW-1:0] HALF_C  = CW'(DEPTH / 2);
   localparam logic [RW-1:0] RECOV_C = RW'(RECOV_CYC);

   logic [RW-1:0] rcnt;
   logic          ready;
   logic          wr_armed;
   logic          wrote_any;
   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] base_fill, limit_fill, fill_nxt;
   logic          wr_ok, rd_ok;

   assign ready  = (rcnt == RECOV_C);
   assign rewind = ~rtx_level;

   always_comb begin
      base_fill = CW'(sfifo_pkg::rewind_fill(int'(wptr), wrote_any, DEPTH));
      limit_fill = rewind ? base_fill : fill;
      wr_ok = ready & wr_rose & wr_armed & (limit_fill != FULL_C);
      rd_ok = ready & rd_fell & ~rewind & (fill != '0);
      if (rewind)
         fill_nxt = base_fill + CW'(wr_ok);
      else
         fill_nxt = fill + CW'(wr_ok) - CW'(rd_ok);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rcnt      <= '0;
         wr_armed  <= 1'b0;
         wrote_any <= 1'b0;
         wptr      <= '0;
         rptr      <= '0;
         fill      <= '0;
         oe        <= 1'b0;
      end else begin
         if (!ready) rcnt <= rcnt + RW'(1);
         wr_armed  <= ready & (wr_fell | (wr_armed & ~wr_rose));
         wrote_any <= wrote_any | wr_ok;
         wptr      <= wptr + AW'(wr_ok);
         rptr      <= rewind ? '0 : rptr + AW'(rd_ok);
         fill      <= fill_nxt;
         if (rd_ok)        oe <= 1'b1;
         else if (rd_rose) oe <= 1'b0;
      end
   end

   assign wr_en   = wr_ok;
   assign wr_addr = wptr;
   assign rd_en   = rd_ok;
   assign rd_addr = rptr;
   assign empty_n = (fill != '0);
   assign half_n  = (fill < HALF_C);
   assign full_n  = (fill != FULL_C);

endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo #(
   parameter int DATA_W      = 9,
   parameter int DEPTH       = 512,
   parameter int RECOV_CYC   = 4,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              mrst_n,
   input  logic              wr_n,
   input  logic              rd_n,
   input  logic              rtx_n,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_oe,
   output logic              empty_n,
   output logic              half_n,
   output logic              full_n
);
   import sfifo_pkg::*;

   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("strobe_fifo: DEPTH must be a power of two of at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("strobe_fifo: DATA_W must be positive");
      end
      if (RECOV_CYC < 1) begin : g_bad_recov
         $error("strobe_fifo: RECOV_CYC must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("strobe_fifo: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic [STROBE_CNT-1:0] strobes;
   strobe_ev_t            evs [STROBE_CNT];

   assign strobes[IDX_WR]  = wr_n;
   assign strobes[IDX_RD]  = rd_n;
   assign strobes[IDX_RTX] = rtx_n;

   generate
      for (genvar g = 0; g < STROBE_CNT; g++) begin : g_edge
         sfifo_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
            .clk      (clk),
            .rst_n    (mrst_n),
            .strobe_n (strobes[g]),
            .ev       (evs[g])
         );
      end
   endgenerate

   logic unused_edge_bits;
   assign unused_edge_bits = ^{evs[IDX_WR].level, evs[IDX_RD].level,
                               evs[IDX_RTX].fell, evs[IDX_RTX].rose};

   logic          wr_en, rd_en, rewind;
   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] fill;

   sfifo_ctrl #(.DEPTH(DEPTH), .RECOV_CYC(RECOV_CYC)) ctrl_i (
      .clk       (clk),
      .rst_n     (mrst_n),
      .wr_fell   (evs[IDX_WR].fell),
      .wr_rose   (evs[IDX_WR].rose),
      .rd_fell   (evs[IDX_RD].fell),
      .rd_rose   (evs[IDX_RD].rose),
      .rtx_level (evs[IDX_RTX].level),
      .wr_en     (wr_en),
      .wr_addr   (wptr),
      .rd_en     (rd_en),
      .rd_addr   (rptr),
      .rewind    (rewind),
      .fill      (fill),
      .oe        (dout_oe),
      .empty_n   (empty_n),
      .half_n    (half_n),
      .full_n    (full_n)
   );

   sfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wptr),
      .wr_data (din),
      .rd_en   (rd_en),
      .rd_addr (rptr),
      .rd_data (dout)
   );

endmodule

// File: rtl/strobe_fifo_chk.sv
module strobe_fifo_chk #(
   parameter int DEPTH = 512,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rewind,
   input logic          empty_n,
   input logic          half_n,
   input logic          full_n,
   input logic          dout_oe,
   input logic [AW-1:0] wptr,
   input logic [AW-1:0] rptr,
   input logic [CW-1:0] fill
);
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= CW'(DEPTH));                                              // R5
   AST_FULL_HAS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      !full_n |-> !half_n);                                             // R5
   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!empty_n && !full_n));                                          // R5
   AST_EMPTY_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty_n && !rewind) |=> (rptr == $past(rptr)));                 // R4
   AST_FULL_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!full_n && !rewind) |=> (wptr == $past(wptr)));                  // R4
   AST_REWIND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rewind |=> (rptr == '0));                                         // R7
   AST_OE_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dout_oe) |-> $past(empty_n));                               // R3

endmodule

bind strobe_fifo strobe_fifo_chk #(.DEPTH(DEPTH)) chk_i (
   .clk     (clk),
   .rst_n   (mrst_n),
   .rewind  (rewind),
   .empty_n (empty_n),
   .half_n  (half_n),
   .full_n  (full_n),
   .dout_oe (dout_oe),
   .wptr    (wptr),
   .rptr    (rptr),
   .fill    (fill)
);

// File: tb/strobe_fifo_tb_top.sv
`timescale 1ns/1ps
module strobe_fifo_tb_top;
   localparam int DEPTH = 512;

   logic       clk = 1'b0;
   logic       mrst_n, wr_n, rd_n, rtx_n;
   logic [8:0] din, dout;
   logic       dout_oe, empty_n, half_n, full_n;

   always #2.5 clk = ~clk;

   strobe_fifo dut_i (
      .clk(clk), .mrst_n(mrst_n), .wr_n(wr_n), .rd_n(rd_n), .rtx_n(rtx_n),
      .din(din), .dout(dout), .dout_oe(dout_oe),
      .empty_n(empty_n), .half_n(half_n), .full_n(full_n)
   );

   // reference model built from the requirements
   logic [8:0] mm [DEPTH];
   int         wp, rp, cnt;
   bit         wrote, in_rtx, done;
   logic [8:0] exp_q [$];
   int         n_chk, n_fail;
   bit         oe_seen;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int base_m();
      if (wp != 0) return wp;
      return wrote ? DEPTH : 0;
   endfunction

   task automatic chk_flags(input string req);
      chk({req, " empty_n"}, empty_n, cnt != 0);
      chk({req, " half_n"},  half_n,  cnt < DEPTH / 2);
      chk({req, " full_n"},  full_n,  cnt != DEPTH);
   endtask

   task automatic settle();
      @(negedge clk);
   endtask

   // monitor: compares each newly enabled read word with the scoreboard
   always @(negedge clk) begin
      if (dout_oe && !oe_seen) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R4 unexpected read word actual %0h expected none", dout);
         end else begin
            logic [8:0] e;
            e = exp_q.pop_front();
            chk("R1 read order", dout, e);
         end
      end
      oe_seen = dout_oe;
   end

   task automatic wr(input logic [8:0] d);
      @(negedge clk) wr_n = 1'b0;
      @(negedge clk) begin din = d; wr_n = 1'b1; end
      if ((in_rtx ? base_m() : cnt) < DEPTH) begin
         mm[wp] = d; wp = (wp + 1) % DEPTH; cnt++; wrote = 1'b1;
      end
   endtask

   task automatic rd();
      bit taken;
      @(negedge clk) rd_n = 1'b0;
      taken = (cnt > 0) && !in_rtx;
      if (taken) begin
         exp_q.push_back(mm[rp]); rp = (rp + 1) % DEPTH; cnt--;
      end
      @(negedge clk);
      if (taken)       chk("R3 oe raised", dout_oe, 1);
      else if (in_rtx) chk("R7 read ignored in replay", dout_oe, 0);
      else             chk("R4 empty read ignored", dout_oe, 0);
      @(negedge clk) rd_n = 1'b1;
   endtask

   task automatic wr_rd(input logic [8:0] d);
      bit rok, wok;
      @(negedge clk) wr_n = 1'b0;
      @(negedge clk) begin din = d; wr_n = 1'b1; rd_n = 1'b0; end
      rok = cnt > 0;
      wok = cnt < DEPTH;
      if (rok) begin exp_q.push_back(mm[rp]); rp = (rp + 1) % DEPTH; end
      if (wok) begin mm[wp] = d; wp = (wp + 1) % DEPTH; wrote = 1'b1; end
      cnt = cnt + int'(wok) - int'(rok);
      @(negedge clk);
      if (!rok) chk("R6 read at empty inhibited", dout_oe, 0);
      @(negedge clk) rd_n = 1'b1;
   endtask

   task automatic rtx_on();
      @(negedge clk) rtx_n = 1'b0;
      in_rtx = 1'b1; rp = 0;
   endtask

   task automatic rtx_off();
      @(negedge clk) rtx_n = 1'b1;
      in_rtx = 1'b0; cnt = base_m();
   endtask

   task automatic do_reset();
      @(negedge clk) begin mrst_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; rtx_n = 1'b1; end
      repeat (3) @(negedge clk);
      mrst_n = 1'b1;
      repeat (8) @(negedge clk);
      wp = 0; rp = 0; cnt = 0; wrote = 1'b0; in_rtx = 1'b0;
      exp_q.delete();
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #(150000 * 5);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      mrst_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; rtx_n = 1'b1; din = '0;
      wp = 0; rp = 0; cnt = 0; wrote = 1'b0; in_rtx = 1'b0;
      repeat (3) @(negedge clk);
      // R9: state while in reset
      chk("R9 reset empty_n", empty_n, 0);
      chk("R9 reset half_n", half_n, 1);
      chk("R9 reset full_n", full_n, 1);
      chk("R9 reset oe", dout_oe, 0);

      // R9: strobes during reset and recovery are discarded
      wr_n = 1'b0;
      @(negedge clk) mrst_n = 1'b1;
      @(negedge clk) wr_n = 1'b1;
      @(negedge clk) wr_n = 1'b0;
      repeat (6) @(negedge clk);
      wr_n = 1'b1;
      settle(); settle();
      chk("R9 recovery write dropped", empty_n, 0);

      // R1 R2 R3: plain traffic
      wr(9'h0A5); wr(9'h15A); wr(9'h1FF);
      settle(); chk_flags("R2 after three writes");
      rd(); rd(); rd();
      settle(); chk("R3 oe cleared", dout_oe, 0);
      chk_flags("R1 drained");

      // R4: empty read does not move the read pointer
      rd();
      wr(9'h1AB); rd();

      // R6: same-clock write and read
      wr(9'h011);
      wr_rd(9'h022);
      settle(); chk_flags("R6 fill unchanged");
      rd();
      wr_rd(9'h033);
      settle(); chk_flags("R6 write only at empty");
      rd();

      // R5: half and full thresholds
      do_reset();
      for (int i = 0; i < 255; i++) wr(9'((i * 37 + 5) % 512));
      settle(); chk("R5 half at 255", half_n, 1);
      wr(9'h0F0);
      settle(); chk("R5 half at 256", half_n, 0);
      chk("R5 not full at 256", full_n, 1);
      for (int i = 256; i < DEPTH; i++) wr(9'((i * 91 + 3) % 512));
      settle(); chk_flags("R5 full");

      // R4: write at full is ignored
      wr(9'h155);
      settle(); chk("R4 full write ignored", full_n, 0);

      // R10: replay at full, then read everything again
      rtx_on(); rtx_off();
      settle(); chk("R10 still full after replay", full_n, 0);
      for (int i = 0; i < DEPTH; i++) rd();
      settle(); chk_flags("R10 drained after replay");

      // R7 R8: replay with read ignored and a write landing
      do_reset();
      for (int i = 0; i < 5; i++) wr(9'(i + 100));
      rd(); rd(); rd();
      rtx_on();
      rd();
      wr(9'h0C3);
      rtx_off();
      settle(); chk_flags("R8 fill after replay");
      for (int i = 0; i < 6; i++) rd();
      settle(); chk_flags("R7 replay drained");

      // R6: same-clock pair at full
      do_reset();
      for (int i = 0; i < DEPTH; i++) wr(9'(i));
      wr_rd(9'h1EE);
      settle(); chk_flags("R6 read only at full");
      settle();

      chk("R1 scoreboard empty", exp_q.size(), 0);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule